// File: doc/BRIEF.md
# CPU Low-Power State Controller

This block decides the operating state of a small processor core and drives the clock enables that follow from it. The core runs in an active state, and it can also be in one of three special states: a reset state, an idle state that stops only the core clock, and a power-down state that stops every clock. Dedicated system-control instruction strobes ask for idle, power-down or a software reset. An asynchronous hardware reset or a watchdog pulse forces the reset state from wherever the controller is.

Each special state has its own way out. Idle returns to active when an interrupt is pending. Power-down ignores interrupts and is left only through a reset. The reset state holds the core reset output for a fixed number of cycles and then hands over to the active state. The controller's own registers run on a free-running, ungated clock, so it can still wake the core from any state.

Top module: `cpu_pwr_state_ctrl`

## Requirements
- R1: While `rst_ni` is low, the controller is in the reset state: `state_o` = 2'b11, `core_rst_o` = 1, and both clock enables = 1.
- R2: A watchdog pulse (`wdt_rst_i` = 1) at a clock edge moves the controller to the reset state (11) from any state. If it was already in reset, the hold count starts again.
- R3: The reset state lasts exactly RST_CYCLES (default 4) clock edges without a watchdog pulse. The controller then becomes active: `state_o` = 2'b00, `core_rst_o` = 0, and both enables = 1.
- R4: In idle (`state_o` = 2'b01), `core_clk_en_o` = 0 and `periph_clk_en_o` = 1.
- R5: In power-down (`state_o` = 2'b10), both `core_clk_en_o` and `periph_clk_en_o` are 0.
- R6: In idle, `irq_pend_i` = 1 at a clock edge moves the controller to active (00).
- R7: In power-down, `irq_pend_i` has no effect. Only a watchdog pulse or a hardware reset ends power-down.
- R8: The idle, power-down and software-reset strobes act only in the active state. In any other state they are ignored.
- R9: When several requests arrive in the active state at the same time, they are served in this order: watchdog, software reset, power-down, idle.
- R10: A software-reset strobe in the active state moves the controller to the reset state (11), which then behaves as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running, ungated controller clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| wdt_rst_i | input | 1 | Watchdog reset pulse |
| sw_rst_req_i | input | 1 | Software-reset instruction strobe |
| idle_req_i | input | 1 | Idle-entry instruction strobe |
| pdn_req_i | input | 1 | Power-down-entry instruction strobe |
| irq_pend_i | input | 1 | Pending interrupt request |
| core_clk_en_o | output | 1 | Clock enable for the CPU core |
| periph_clk_en_o | output | 1 | Clock enable for the on-chip peripherals |
| core_rst_o | output | 1 | Reset to the CPU core, active high |
| state_o | output | 2 | Current state: 00 active, 01 idle, 10 power-down, 11 reset |

## Verification
Directed sequences cover the following:
- every entry strobe in the active state and again in idle, power-down and reset;
- an interrupt in idle and in power-down, which shows the wake-up source depends on the state;
- simultaneous idle and power-down strobes, and a software reset together with power-down, which show the priority order;
- a watchdog pulse partway through the reset hold, which shows the count restarts.

After that, random strobes from a fixed seed are applied, with interrupts made dense and resets made rare, so that long stays in idle and power-down occur. Short asynchronous hardware-reset pulses are mixed in. Every cycle is compared against a reference model of the state sequence written in the bench.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

    typedef enum logic [1:0] {
        PS_ACTIVE = 2'b00,
        PS_IDLE   = 2'b01,
        PS_PDOWN  = 2'b10,
        PS_RESET  = 2'b11
    } pwr_state_e;

endpackage

// File: rtl/pwr_entry_arb.sv
module pwr_entry_arb
    import pwr_state_pkg::*;
(
    input  logic       is_active_i,
    input  logic       wdt_i,
    input  logic       sw_rst_i,
    input  logic       pdn_i,
    input  logic       idle_i,
    output logic       hit_o,
    output pwr_state_e tgt_o
);

    // Watchdog wins from any state; instruction strobes only count when active.
    always_comb begin
        hit_o = 1'b0;
        tgt_o = PS_ACTIVE;
        if (wdt_i) begin
            hit_o = 1'b1;
            tgt_o = PS_RESET;
        end else if (is_active_i) begin
            if (sw_rst_i) begin
                hit_o = 1'b1;
                tgt_o = PS_RESET;
            end else if (pdn_i) begin
                hit_o = 1'b1;
                tgt_o = PS_PDOWN;
            end else if (idle_i) begin
                hit_o = 1'b1;
                tgt_o = PS_IDLE;
            end
        end
    end

endmodule

// File: rtl/pwr_rst_timer.sv
module pwr_rst_timer #(
    parameter int RST_CYCLES = 4,
    parameter int CNT_W      = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1
) (
    input  logic             in_reset_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYCLES - 1);

    always_comb begin
        done_o = in_reset_i && !restart_i && (cnt_i == LAST);
        if (restart_i || !in_reset_i || done_o) begin
            cnt_o = '0;
        end else begin
            cnt_o = cnt_i + 1'b1;
        end
    end

endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
    import pwr_state_pkg::*;
(
    input  pwr_state_e st_i,
    output logic       core_en_o,
    output logic       periph_en_o,
    output logic       core_rst_o
);

    always_comb begin
        unique case (st_i)
            PS_ACTIVE: begin core_en_o = 1'b1; periph_en_o = 1'b1; core_rst_o = 1'b0; end
            PS_IDLE:   begin core_en_o = 1'b0; periph_en_o = 1'b1; core_rst_o = 1'b0; end
            PS_PDOWN:  begin core_en_o = 1'b0; periph_en_o = 1'b0; core_rst_o = 1'b0; end
            default:   begin core_en_o = 1'b1; periph_en_o = 1'b1; core_rst_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/cpu_pwr_state_ctrl.sv
module cpu_pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wdt_rst_i,
    input  logic       sw_rst_req_i,
    input  logic       idle_req_i,
    input  logic       pdn_req_i,
    input  logic       irq_pend_i,
    output logic       core_clk_en_o,
    output logic       periph_clk_en_o,
    output logic       core_rst_o,
    output logic [1:0] state_o
);

    localparam int CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;

    typedef struct packed {
        pwr_state_e       st;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t             ctrl_d, ctrl_q;
    logic              arb_hit;
    pwr_state_e        arb_tgt;
    logic              tmr_restart;
    logic              tmr_done;
    logic [CNT_W-1:0]  tmr_cnt;

    pwr_entry_arb u_arb (
        .is_active_i (ctrl_q.st == PS_ACTIVE),
        .wdt_i       (wdt_rst_i),
        .sw_rst_i    (sw_rst_req_i),
        .pdn_i       (pdn_req_i),
        .idle_i      (idle_req_i),
        .hit_o       (arb_hit),
        .tgt_o       (arb_tgt)
    );

    assign tmr_restart = arb_hit && (arb_tgt == PS_RESET);

    pwr_rst_timer #(
        .RST_CYCLES (RST_CYCLES),
        .CNT_W      (CNT_W)
    ) u_tmr (
        .in_reset_i (ctrl_q.st == PS_RESET),
        .restart_i  (tmr_restart),
        .cnt_i      (ctrl_q.cnt),
        .cnt_o      (tmr_cnt),
        .done_o     (tmr_done)
    );

    always_comb begin
        ctrl_d     = ctrl_q;
        ctrl_d.cnt = tmr_cnt;
        if (arb_hit) begin
            ctrl_d.st = arb_tgt;
        end else begin
            unique case (ctrl_q.st)
                PS_IDLE:  if (irq_pend_i) ctrl_d.st = PS_ACTIVE;
                PS_RESET: if (tmr_done)   ctrl_d.st = PS_ACTIVE;
                default:  ctrl_d.st = ctrl_q.st;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q.st  <= PS_RESET;
            ctrl_q.cnt <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    pwr_out_decode u_dec (
        .st_i        (ctrl_q.st),
        .core_en_o   (core_clk_en_o),
        .periph_en_o (periph_clk_en_o),
        .core_rst_o  (core_rst_o)
    );

    assign state_o = ctrl_q.st;

endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk #(
    parameter int RST_CYCLES = 4
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       wdt_rst_i,
    input logic       sw_rst_req_i,
    input logic       idle_req_i,
    input logic       pdn_req_i,
    input logic       irq_pend_i,
    input logic       core_clk_en_o,
    input logic       periph_clk_en_o,
    input logic       core_rst_o,
    input logic [1:0] state_o
);

    logic [15:0] run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              run_q <= '0;
        else if (state_o != 2'b11 || wdt_rst_i)   run_q <= '0;
        else                                      run_q <= run_q + 16'd1;
    end

    a_r1_reset_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b11) |-> (core_rst_o && core_clk_en_o && periph_clk_en_o));

    a_r2_wdt_forces_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdt_rst_i |=> (state_o == 2'b11));

    a_r3_hold_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b11 && !wdt_rst_i && run_q == 16'(RST_CYCLES - 1)) |=> (state_o == 2'b00));

    a_r3_hold_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b11 && !wdt_rst_i && run_q < 16'(RST_CYCLES - 1)) |=> (state_o == 2'b11));

    a_r4_idle_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b01) |-> (!core_clk_en_o && periph_clk_en_o && !core_rst_o));

    a_r5_pdown_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b10) |-> (!core_clk_en_o && !periph_clk_en_o && !core_rst_o));

    a_r6_idle_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b01 && irq_pend_i && !wdt_rst_i) |=> (state_o == 2'b00));

    a_r7_pdown_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b10 && !wdt_rst_i) |=> (state_o == 2'b10));

    a_r8_idle_ignores_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b01 && !irq_pend_i && !wdt_rst_i && (sw_rst_req_i || pdn_req_i || idle_req_i))
        |=> (state_o == 2'b01));

    a_r9_pdn_over_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b00 && !wdt_rst_i && !sw_rst_req_i && pdn_req_i) |=> (state_o == 2'b10));

    a_r10_sw_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_o == 2'b00 && sw_rst_req_i) |=> (state_o == 2'b11));

endmodule

bind cpu_pwr_state_ctrl pwr_state_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wdt_rst_i       (wdt_rst_i),
    .sw_rst_req_i    (sw_rst_req_i),
    .idle_req_i      (idle_req_i),
    .pdn_req_i       (pdn_req_i),
    .irq_pend_i      (irq_pend_i),
    .core_clk_en_o   (core_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .core_rst_o      (core_rst_o),
    .state_o         (state_o)
);

// File: tb/cpu_pwr_state_ctrl_tb.sv
module cpu_pwr_state_ctrl_tb;

    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       wdt = 1'b0, swr = 1'b0, idl = 1'b0, pdn = 1'b0, irq = 1'b0;
    logic       core_en, per_en, core_rst;
    logic [1:0] st;

    int n_run  = 0;
    int n_fail = 0;

    logic [1:0] m_st  = 2'b11;
    int         m_cnt = 0;

    always #10 clk = ~clk;

    cpu_pwr_state_ctrl #(.RST_CYCLES(HOLD)) u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .wdt_rst_i       (wdt),
        .sw_rst_req_i    (swr),
        .idle_req_i      (idl),
        .pdn_req_i       (pdn),
        .irq_pend_i      (irq),
        .core_clk_en_o   (core_en),
        .periph_clk_en_o (per_en),
        .core_rst_o      (core_rst),
        .state_o         (st)
    );

    // Expected {state, core_en, periph_en, core_rst} for a model state (R1, R4, R5, R3).
    function automatic logic [4:0] exp_out(input logic [1:0] s);
        case (s)
            2'b00:   return {s, 3'b110};
            2'b01:   return {s, 3'b010};
            2'b10:   return {s, 3'b000};
            default: return {s, 3'b111};
        endcase
    endfunction

    // Reference next-state step from the requirements.
    task automatic model_step();
        if (wdt) begin                                   // R2
            m_st = 2'b11; m_cnt = 0;
        end else begin
            case (m_st)
                2'b00: begin                             // R9 order, R8 only here
                    if (swr)      begin m_st = 2'b11; m_cnt = 0; end   // R10
                    else if (pdn) m_st = 2'b10;
                    else if (idl) m_st = 2'b01;
                end
                2'b01: if (irq) m_st = 2'b00;            // R6
                2'b10: ;                                 // R7
                default: begin                           // R3
                    if (m_cnt == HOLD - 1) begin m_st = 2'b00; m_cnt = 0; end
                    else m_cnt++;
                end
            endcase
        end
    endtask

    task automatic check(input string tag);
        logic [4:0] act, exp;
        act = {st, core_en, per_en, core_rst};
        exp = exp_out(m_st);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got st/core/per/rst=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic w, input logic s, input logic i, input logic p, input logic q);
        wdt = w; swr = s; idl = i; pdn = p; irq = q;
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag);
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        m_st = 2'b11; m_cnt = 0;
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
    endtask

    function automatic string rnd_tag(input logic [1:0] s);
        case (s)
            2'b00:   return "R9";
            2'b01:   return "R4";
            2'b10:   return "R7";
            default: return "R3";
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        hw_reset();
        drive(0, 0, 0, 0, 0);
        for (int k = 0; k < HOLD - 1; k++) cyc("R3");
        cyc("R3");                                       // now active
        drive(0, 0, 1, 0, 0); cyc("R4");                 // idle
        drive(0, 0, 0, 1, 0); cyc("R8");                 // pdn strobe ignored in idle
        drive(0, 1, 0, 0, 0); cyc("R8");                 // sw reset ignored in idle
        drive(0, 0, 0, 0, 1); cyc("R6");                 // wake to active
        drive(0, 0, 1, 1, 0); cyc("R9");                 // pdn beats idle
        drive(0, 0, 0, 0, 1); cyc("R7");                 // irq ignored in pdn
        drive(0, 1, 1, 0, 1); cyc("R8");                 // strobes ignored in pdn
        check("R5");
        drive(1, 0, 0, 0, 0); cyc("R2");                 // wdt leaves pdn
        drive(0, 0, 0, 0, 0);
        for (int k = 0; k < HOLD; k++) cyc("R3");
        drive(0, 1, 0, 1, 0); cyc("R10");                // sw reset beats pdn
        drive(0, 0, 0, 0, 0); cyc("R10"); cyc("R10");
        drive(1, 0, 0, 0, 0); cyc("R2");                 // restart hold
        drive(0, 0, 0, 0, 0);
        for (int k = 0; k < HOLD; k++) cyc("R3");
        drive(1, 1, 1, 1, 1); cyc("R9");                 // wdt beats everything

        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 199) == 0) begin
                drive(0, 0, 0, 0, 0);
                hw_reset();
            end else begin
                drive($urandom_range(0, 59) == 0,
                      $urandom_range(0, 29) == 0,
                      $urandom_range(0, 5) == 0,
                      $urandom_range(0, 9) == 0,
                      $urandom_range(0, 3) == 0);
                cyc(rnd_tag(m_st));
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2ms;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule